// File: doc/BRIEF.md
# In-Order Read Data Checker

This block sits beside a memory traffic source and verifies returned read data. Each time the source issues a read it pushes the value that read should return; the checker queues those values in issue order. Every returned read word is matched against the oldest queued value, and the queue entry is retired whether the match succeeds or not.

The checker does not stop at the first bad word. It marks the failure, records the 0-based index of the first bad response, and keeps consuming responses. The fail verdict appears only once nothing is outstanding, so the controller sees a single verdict after the traffic has fully drained. Two protocol faults also set the sticky error flag: a push into a full queue, and a response that arrives with nothing queued.

Top module: `inorder_rd_checker`

## Requirements
- R1: A push on `exp_valid_i` stores `exp_data_i` at the tail of the queue and raises `outstanding_o` by one after the clock edge.
- R2: A response on `rsp_valid_i` with at least one entry queued is compared with the oldest entry. That entry is removed, and `cmp_count_o` rises by one after the edge.
- R3: A compared response whose data differs from the oldest entry sets `mismatch_o` and `error_o`. Both stay high until reset, and later responses are still compared and retired.
- R4: On the first mismatch, `first_bad_vld_o` goes high and `first_bad_idx_o` takes the value `cmp_count_o` had before that response, which is the 0-based response index. Both hold until reset, even if later responses also mismatch.
- R5: `fail_o` is high only when `error_o` and `drained_o` are both high. `pass_o` is high only when `drained_o` is high, `error_o` is low and `cmp_count_o` is nonzero.
- R6: `drained_o` is high exactly when `outstanding_o` is zero and `exp_valid_i` is low in the same cycle.
- R7: A push when `outstanding_o` equals DEPTH and no response arrives in that cycle is dropped. It sets `overflow_o` and `error_o`, and `outstanding_o` stays at DEPTH.
- R8: A response while `outstanding_o` is zero is not compared. It sets `underflow_o` and `error_o` and leaves `cmp_count_o` unchanged.
- R9: A push and a valid response in the same cycle are both accepted, even when the queue is full, and `outstanding_o` is unchanged.
- R10: After reset, all counts, flags and verdicts are zero and `drained_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exp_valid_i | input | 1 | Push expected value for an issued read |
| exp_data_i | input | DATA_W | Expected read data |
| rsp_valid_i | input | 1 | Returned read word valid |
| rsp_data_i | input | DATA_W | Returned read word |
| outstanding_o | output | $clog2(DEPTH+1) | Reads issued and not yet returned |
| cmp_count_o | output | CNT_W | Responses compared since reset |
| drained_o | output | 1 | Nothing outstanding and no push this cycle |
| error_o | output | 1 | Sticky: any mismatch or protocol fault |
| mismatch_o | output | 1 | Sticky: a data mismatch occurred |
| overflow_o | output | 1 | Sticky: push into a full queue |
| underflow_o | output | 1 | Sticky: response with empty queue |
| first_bad_vld_o | output | 1 | First mismatch index is valid |
| first_bad_idx_o | output | CNT_W | 0-based index of the first mismatching response |
| pass_o | output | 1 | Drained, error-free, at least one compare |
| fail_o | output | 1 | Drained with error set |

## Verification
The bench builds the checker with DEPTH=4, DATA_W=16 and CNT_W=8. With a queue of four entries, a short burst of five pushes reaches the full boundary. That makes the dropped push and the simultaneous push-and-pop at full cheap to exercise. The 16-bit data still gives distinct patterns for mismatch detection, and the 8-bit counter keeps the index values readable while staying well clear of wrap.

// File: rtl/rdchk_pkg.sv
package rdchk_pkg;
  typedef struct packed {
    logic overflow;
    logic underflow;
  } proto_err_t;
endpackage

// File: rtl/rdchk_fifo.sv
module rdchk_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [OCC_W-1:0]  count_o,
  output logic              empty_o,
  output logic              push_ok_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic              full, do_pop;

  assign full      = (count_o == OCC_W'(DEPTH));
  assign empty_o   = (count_o == '0);
  assign do_pop    = pop_i & ~empty_o;
  assign push_ok_o = push_i & (~full | do_pop);
  assign head_o    = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_o <= '0;
    end else begin
      if (push_ok_o) wr_q <= nxt(wr_q);
      if (do_pop)    rd_q <= nxt(rd_q);
      case ({push_ok_o, do_pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  // storage without reset; only read when count is nonzero
  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/rdchk_cmp.sv
module rdchk_cmp #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rsp_ok_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  input  logic [DATA_W-1:0] head_i,
  output logic [CNT_W-1:0]  cmp_count_o,
  output logic              mismatch_o,
  output logic              first_bad_vld_o,
  output logic [CNT_W-1:0]  first_bad_idx_o
);
  logic bad;
  assign bad = rsp_ok_i & (rsp_data_i != head_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_count_o     <= '0;
      mismatch_o      <= 1'b0;
      first_bad_vld_o <= 1'b0;
      first_bad_idx_o <= '0;
    end else begin
      if (rsp_ok_i) cmp_count_o <= cmp_count_o + 1'b1;
      if (bad) mismatch_o <= 1'b1;
      if (bad && !first_bad_vld_o) begin
        first_bad_vld_o <= 1'b1;
        first_bad_idx_o <= cmp_count_o;
      end
    end
  end
endmodule

// File: rtl/inorder_rd_checker.sv
module inorder_rd_checker
  import rdchk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       exp_valid_i,
  input  logic [DATA_W-1:0]          exp_data_i,
  input  logic                       rsp_valid_i,
  input  logic [DATA_W-1:0]          rsp_data_i,
  output logic [$clog2(DEPTH+1)-1:0] outstanding_o,
  output logic [CNT_W-1:0]           cmp_count_o,
  output logic                       drained_o,
  output logic                       error_o,
  output logic                       mismatch_o,
  output logic                       overflow_o,
  output logic                       underflow_o,
  output logic                       first_bad_vld_o,
  output logic [CNT_W-1:0]           first_bad_idx_o,
  output logic                       pass_o,
  output logic                       fail_o
);
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] head;
  logic              empty, push_ok, rsp_ok;
  proto_err_t        perr_q;

  assign rsp_ok = rsp_valid_i & ~empty;

  rdchk_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(exp_valid_i), .data_i(exp_data_i), .pop_i(rsp_valid_i),
    .head_o(head), .count_o(outstanding_o), .empty_o(empty), .push_ok_o(push_ok)
  );

  rdchk_cmp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cmp (
    .clk_i, .rst_ni,
    .rsp_ok_i(rsp_ok), .rsp_data_i, .head_i(head),
    .cmp_count_o, .mismatch_o, .first_bad_vld_o, .first_bad_idx_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) perr_q <= '0;
    else begin
      if (exp_valid_i && !push_ok) perr_q.overflow  <= 1'b1;
      if (rsp_valid_i && empty)    perr_q.underflow <= 1'b1;
    end
  end

  assign overflow_o  = perr_q.overflow;
  assign underflow_o = perr_q.underflow;
  assign error_o     = mismatch_o | perr_q.overflow | perr_q.underflow;
  assign drained_o   = (outstanding_o == OCC_W'(0)) & ~exp_valid_i;
  assign fail_o      = drained_o & error_o;
  assign pass_o      = drained_o & ~error_o & (cmp_count_o != '0);
endmodule

// File: rtl/rdchk_checker.sv
module rdchk_checker #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 16,
  parameter int OCC_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             exp_valid_i,
  input logic             rsp_valid_i,
  input logic [OCC_W-1:0] outstanding_o,
  input logic [CNT_W-1:0] cmp_count_o,
  input logic             drained_o,
  input logic             error_o,
  input logic             mismatch_o,
  input logic             first_bad_vld_o,
  input logic [CNT_W-1:0] first_bad_idx_o,
  input logic             pass_o,
  input logic             fail_o
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outstanding_o <= OCC_W'(DEPTH)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o); // R3
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_bad_vld_o |=> first_bad_vld_o && $stable(first_bad_idx_o)); // R4
  AST_FAIL_AFTER_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> drained_o && error_o); // R5
  AST_VERDICT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o)); // R5
  AST_EMPTY_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && outstanding_o == '0 |=> error_o && $stable(cmp_count_o)); // R8
  AST_BOTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_valid_i && rsp_valid_i && outstanding_o != '0 |=> $stable(outstanding_o)); // R9
  AST_MISMATCH_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |-> error_o); // R3
endmodule

bind inorder_rd_checker rdchk_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OCC_W(OCC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .exp_valid_i(exp_valid_i), .rsp_valid_i(rsp_valid_i),
  .outstanding_o(outstanding_o), .cmp_count_o(cmp_count_o), .drained_o(drained_o),
  .error_o(error_o), .mismatch_o(mismatch_o), .first_bad_vld_o(first_bad_vld_o),
  .first_bad_idx_o(first_bad_idx_o), .pass_o(pass_o), .fail_o(fail_o)
);

// File: tb/sim_inorder_rd_checker.sv
`timescale 1ns/1ps
module sim_inorder_rd_checker;
  localparam int DW = 16, DEPTH = 4, CW = 8, OW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic push = 1'b0, rsp = 1'b0;
  logic [DW-1:0] pdata = '0, rdata = '0;
  logic [OW-1:0] outst;
  logic [CW-1:0] cmpc, bidx;
  logic drained, err, mism, ovf, unf, bvld, pass, fail;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  inorder_rd_checker #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .exp_valid_i(push), .exp_data_i(pdata),
    .rsp_valid_i(rsp), .rsp_data_i(rdata), .outstanding_o(outst), .cmp_count_o(cmpc),
    .drained_o(drained), .error_o(err), .mismatch_o(mism), .overflow_o(ovf),
    .underflow_o(unf), .first_bad_vld_o(bvld), .first_bad_idx_o(bidx),
    .pass_o(pass), .fail_o(fail)
  );

  typedef struct packed {
    logic push; logic [DW-1:0] pd; logic rsp; logic [DW-1:0] rd;
    logic [OW-1:0] outst; logic [CW-1:0] cmpc; logic err; logic fail;
  } vec_t;

  localparam vec_t TBL [7] = '{
    '{1'b1, 16'hA001, 1'b0, 16'h0000, 3'd1, 8'd0, 1'b0, 1'b0},
    '{1'b1, 16'hA002, 1'b0, 16'h0000, 3'd2, 8'd0, 1'b0, 1'b0},
    '{1'b1, 16'hA003, 1'b0, 16'h0000, 3'd3, 8'd0, 1'b0, 1'b0},
    '{1'b0, 16'h0000, 1'b1, 16'hA001, 3'd2, 8'd1, 1'b0, 1'b0},
    '{1'b1, 16'hA004, 1'b1, 16'hA002, 3'd2, 8'd2, 1'b0, 1'b0},
    '{1'b0, 16'h0000, 1'b1, 16'hBAD0, 3'd1, 8'd3, 1'b1, 1'b0},
    '{1'b0, 16'h0000, 1'b1, 16'hA004, 3'd0, 8'd4, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic [DW-1:0] pd, input logic r, input logic [DW-1:0] rd);
    @(negedge clk);
    push = p; pdata = pd; rsp = r; rdata = rd;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    push = 1'b0; rsp = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; push = 1'b0; rsp = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R10 outstanding", 32'(outst), 0);
    chk("R10 drained", 32'(drained), 1);
    chk("R10 error/pass/fail", {29'd0, err, pass, fail}, 0);
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R9 R5
    for (int i = 0; i < 7; i++) begin
      step(TBL[i].push, TBL[i].pd, TBL[i].rsp, TBL[i].rd);
      chk("R1/R9 outstanding", 32'(outst), 32'(TBL[i].outst));
      chk("R2 cmp_count", 32'(cmpc), 32'(TBL[i].cmpc));
      chk("R3 error", 32'(err), 32'(TBL[i].err));
      chk("R5 fail", 32'(fail), 32'(TBL[i].fail));
    end
    idle();
    chk("R4 first_bad_vld", 32'(bvld), 1);
    chk("R4 first_bad_idx", 32'(bidx), 2);
    chk("R5 pass low on error", 32'(pass), 0);
    chk("R3 mismatch", 32'(mism), 1);

    // second mismatch keeps first index: R4
    step(1'b1, 16'h1111, 1'b0, '0);
    step(1'b0, '0, 1'b1, 16'h2222);
    idle();
    chk("R4 index held", 32'(bidx), 2);
    chk("R3 still compared", 32'(cmpc), 5);

    // pass path: R5 R6
    do_reset();
    step(1'b1, 16'h5A5A, 1'b0, '0);
    @(negedge clk); push = 1'b1; pdata = 16'h0F0F; rsp = 1'b0; #1;
    chk("R6 drained low with push", 32'(drained), 0);
    @(posedge clk); #1;
    step(1'b0, '0, 1'b1, 16'h5A5A);
    step(1'b0, '0, 1'b1, 16'h0F0F);
    idle();
    chk("R6 drained", 32'(drained), 1);
    chk("R5 pass", 32'(pass), 1);
    chk("R5 fail low", 32'(fail), 0);
    @(negedge clk); push = 1'b1; pdata = 16'h0001; #1;
    chk("R5 no pass while push", 32'(pass), 0);
    @(posedge clk); #1;
    step(1'b0, '0, 1'b1, 16'h0001);

    // overflow: R7 R9
    do_reset();
    for (int k = 0; k < 4; k++) step(1'b1, 16'(16'h100 + k), 1'b0, '0);
    chk("R7 full", 32'(outst), 4);
    chk("R7 no error yet", 32'(err), 0);
    step(1'b1, 16'hDEAD, 1'b0, '0);
    chk("R7 outstanding stays", 32'(outst), 4);
    chk("R7 overflow", 32'(ovf), 1);
    chk("R7 error", 32'(err), 1);
    step(1'b1, 16'h0104, 1'b1, 16'h0100);
    chk("R9 push+pop at full", 32'(outst), 4);
    for (int k = 1; k < 5; k++) step(1'b0, '0, 1'b1, 16'(16'h100 + k));
    idle();
    chk("R7 dropped push not queued", 32'(mism), 0);
    chk("R5 fail after drain", 32'(fail), 1);

    // underflow: R8
    do_reset();
    step(1'b0, '0, 1'b1, 16'h7777);
    idle();
    chk("R8 underflow", 32'(unf), 1);
    chk("R8 error", 32'(err), 1);
    chk("R8 cmp_count unchanged", 32'(cmpc), 0);
    chk("R8 outstanding", 32'(outst), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule